// File: doc/BRIEF.md
# PLL Divider Search Engine

A sequential search unit that picks the divider settings for a clock synthesiser. It is given a requested output frequency, the reference frequency, the inclusive VCO operating range and a ceiling on the output frequency, all as unsigned integers in kHz. It returns three settings: a reference divider M, a feedback multiplier N and a power-of-two post divider P. Together they bring reference × N / (M × P) as close as it can get to the request.

A single-cycle `start` pulse latches the inputs, clamps the request into the range the PLL can reach and then walks the post-divider steps in ascending order. For each accepted post divider it walks the reference divider in ascending order. For every pair that passes the phase-detector window, a shared restoring divider computes the rounded feedback multiplier. The candidate is then scored by an exact rational error comparison.

When the scan ends, the same divider produces the achieved frequency. The engine then presents M, N, the encoded P, a packed register byte and the achieved frequency, and raises `done`. If no candidate qualified, `invalid` is raised instead and every setting reads zero.

Top module: `pll_divider_search`

## Requirements
- R1: The effective request is the input request raised to at least floor(vco_min_khz / 8) and then lowered to at most max_out_khz; all scoring uses this effective request.
- R2: Post divider values 1, 2, 4, 8 are examined in that order, and a value is used only when effective request × P lies within vco_min_khz..vco_max_khz inclusive.
- R3: M runs from 1 to 63 in ascending order and is used only when 2000 × M ≤ ref_khz ≤ 3600 × M (reference / M inside 2000..3600 kHz inclusive).
- R4: N = floor((2 × F_vco × M + ref_khz) / (2 × ref_khz)) with F_vco = effective request × P, and a candidate is accepted only when 1 ≤ N ≤ 127.
- R5: The error of a candidate is |effective request − ref_khz × N / (M × P)|, compared exactly. A candidate replaces the best only when its error is strictly smaller, so on a tie the earlier candidate in scan order is kept.
- R6: `p_code` encodes the chosen post divider as 1→0, 2→1, 4→2, 8→3.
- R7: `pll_byte` carries M in bits 5:0 and the P code in bits 7:6; `n_sel` is the 7-bit N.
- R8: `achieved_khz` = floor(ref_khz × N / (M × P)) for the chosen settings, saturated to all ones if it does not fit.
- R9: When no candidate qualifies, `invalid` is 1 and `m_sel`, `n_sel`, `p_code`, `pll_byte` and `achieved_khz` are all zero.
- R10: `start` while idle begins a search: `busy` rises and `done` falls on the next cycle. `done` and `busy` are never high together. Results hold while `done` is high until the next accepted start. `start` while busy is ignored.
- R11: After reset `busy`, `done`, `invalid` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a search |
| req_khz | input | FW | Requested output frequency, kHz |
| ref_khz | input | FW | Reference frequency, kHz |
| vco_min_khz | input | FW | Lowest allowed VCO frequency, kHz |
| vco_max_khz | input | FW | Highest allowed VCO frequency, kHz |
| max_out_khz | input | FW | Ceiling on the output frequency for the current mode, kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | Results valid; held until the next accepted start |
| invalid | output | 1 | No qualifying candidate was found |
| m_sel | output | 6 | Chosen reference divider |
| n_sel | output | 7 | Chosen feedback multiplier |
| p_code | output | 2 | Encoded post divider |
| pll_byte | output | 8 | {p_code, m_sel} |
| achieved_khz | output | FW | Output frequency of the chosen settings, kHz |

## Verification
A search lasts a data-dependent number of cycles: one cycle per skipped (P, M) step, plus 33 cycles per scored candidate (31 divider steps, the hand-off and the scoring), plus a final division of the same length. The results are therefore due only in the cycle `done` rises. The bench computes each job's expected settings and achieved frequency from the requirements when the start is accepted. On every falling edge it compares all result ports whenever `done` is high, and checks that `busy` and `done` are never high together. It also requires `done` to appear within a bound well above the worst-case scan length. It keeps comparing for several cycles after completion while it changes the inputs and pulses `start` mid-search, which checks that results hold and that a busy start is ignored.

// File: rtl/pll_search_pkg.sv
`timescale 1ns/1ps
package pll_search_pkg;

    // Field widths fixed by the packed register byte
    localparam int M_W  = 6;
    localparam int N_W  = 7;
    localparam int PE_W = 2;

    // Scan limits
    localparam int P_STEPS = 4;     // post divider 1,2,4,8
    localparam int M_FIRST = 1;
    localparam int M_LAST  = 63;
    localparam int N_LO    = 1;
    localparam int N_HI    = 127;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DIVN,
        ST_EVAL,
        ST_FIN,
        ST_DIVF
    } srch_state_e;

    typedef struct packed {
        logic [PE_W-1:0] pe;
        logic [M_W-1:0]  m;
        logic [N_W-1:0]  n;
    } pll_pick_t;

    // Phase-detector window test without a division
    function automatic logic win_ok(input int unsigned ref_v, input int unsigned m_v,
                                    input int unsigned lo, input int unsigned hi);
        return (ref_v >= lo * m_v) && (ref_v <= hi * m_v);
    endfunction

    function automatic logic [7:0] pack_byte(input pll_pick_t s);
        return {s.pe, s.m};
    endfunction

endpackage

// File: rtl/pll_req_clamp.sv
`timescale 1ns/1ps
module pll_req_clamp
    import pll_search_pkg::*;
#(
    parameter int FW = 20
) (
    input  logic [FW-1:0] req_i,
    input  logic [FW-1:0] vco_min_i,
    input  logic [FW-1:0] max_out_i,
    output logic [FW-1:0] req_o
);
    localparam int SHIFT = P_STEPS - 1;

    logic [FW-1:0] floor_v;
    logic [FW-1:0] raised;

    always_comb begin
        floor_v = vco_min_i >> SHIFT;
        raised  = (req_i < floor_v) ? floor_v : req_i;
        req_o   = (raised > max_out_i) ? max_out_i : raised;
    end
endmodule

// File: rtl/pll_div_restoring.sv
`timescale 1ns/1ps
module pll_div_restoring #(
    parameter int NUM_W = 31,
    parameter int DEN_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o
);
    localparam int CNT_W  = $clog2(NUM_W + 1);
    localparam int PROD_W = NUM_W + DEN_W;

    logic [NUM_W-1:0] shift_q;
    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DEN_W:0]   trial;
    logic             ge;

    assign trial  = {rem_q, shift_q[NUM_W-1]};
    assign ge     = (trial >= {1'b0, den_q});
    assign quot_o = shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            num_q   <= '0;
            den_q   <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                shift_q <= num_i;
                num_q   <= num_i;
                den_q   <= den_i;
                rem_q   <= '0;
                cnt_q   <= CNT_W'(NUM_W);
                run_q   <= 1'b1;
            end else if (run_q) begin
                rem_q   <= ge ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
                shift_q <= {shift_q[NUM_W-2:0], ge};
                cnt_q   <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // R4: quotient and remainder are exact for the latched operands
    a_r4_quotient_exact: assert property (@(posedge clk) disable iff (rst)
        (done_o && den_q != '0) |->
            ((PROD_W'(quot_o) * PROD_W'(den_q) + PROD_W'(rem_q) == PROD_W'(num_q))
             && (rem_q < den_q)));
endmodule

// File: rtl/pll_cand_eval.sv
`timescale 1ns/1ps
module pll_cand_eval
    import pll_search_pkg::*;
#(
    parameter int FW    = 20,
    parameter int QW    = 31,
    parameter int ERR_W = 29,
    parameter int DEN_W = 9
) (
    input  logic [FW-1:0]    req_i,
    input  logic [FW-1:0]    ref_i,
    input  logic [M_W-1:0]   m_i,
    input  logic [PE_W-1:0]  pe_i,
    input  logic [QW-1:0]    n_i,
    input  logic             found_i,
    input  logic [ERR_W-1:0] best_err_i,
    input  logic [DEN_W-1:0] best_den_i,
    output logic             take_o,
    output logic [ERR_W-1:0] err_o,
    output logic [DEN_W-1:0] den_o
);
    localparam int PW = ERR_W + DEN_W;

    logic             n_ok;
    logic [ERR_W-1:0] target;
    logic [ERR_W-1:0] got;
    logic [PW-1:0]    lhs;
    logic [PW-1:0]    rhs;

    always_comb begin
        n_ok   = (n_i >= QW'(N_LO)) && (n_i <= QW'(N_HI));
        // error scaled by M*P: |req*M*P - ref*N|
        target = (ERR_W'(req_i) * ERR_W'(m_i)) << pe_i;
        got    = ERR_W'(ref_i) * ERR_W'(n_i[N_W-1:0]);
        err_o  = (target >= got) ? (target - got) : (got - target);
        den_o  = DEN_W'(m_i) << pe_i;
        // exact fraction compare: err/den < best_err/best_den
        lhs    = PW'(err_o) * PW'(best_den_i);
        rhs    = PW'(best_err_i) * PW'(den_o);
        take_o = n_ok && (!found_i || (lhs < rhs));
    end
endmodule

// File: rtl/pll_divider_search.sv
`timescale 1ns/1ps
module pll_divider_search
    import pll_search_pkg::*;
#(
    parameter int FW          = 20,
    parameter int WIN_LO_KHZ  = 2000,
    parameter int WIN_HI_KHZ  = 3600
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [FW-1:0]   req_khz,
    input  logic [FW-1:0]   ref_khz,
    input  logic [FW-1:0]   vco_min_khz,
    input  logic [FW-1:0]   vco_max_khz,
    input  logic [FW-1:0]   max_out_khz,
    output logic            busy,
    output logic            done,
    output logic            invalid,
    output logic [5:0]      m_sel,
    output logic [6:0]      n_sel,
    output logic [1:0]      p_code,
    output logic [7:0]      pll_byte,
    output logic [FW-1:0]   achieved_khz
);
    localparam int VW     = FW + P_STEPS - 1;
    localparam int DNUM_W = VW + M_W + 2;
    localparam int DDEN_W = FW + 1;
    localparam int ERR_W  = FW + M_W + P_STEPS - 1;
    localparam int MPW    = M_W + P_STEPS - 1;

    srch_state_e      state_q;
    logic [FW-1:0]    req_eff;
    logic [FW-1:0]    req_r, ref_r, vmin_r, vmax_r, maxo_r;
    logic [PE_W-1:0]  pe_q;
    logic [M_W-1:0]   m_q;
    logic [DNUM_W-1:0] n_q;
    logic             found_q;
    pll_pick_t        best_q;
    logic [ERR_W-1:0] best_err_q;
    logic [MPW-1:0]   best_den_q;
    pll_pick_t        sel_q;

    logic [VW-1:0]    fvco;
    logic             vco_bad, win_pass, adv_p, scan_end;
    logic             div_start, div_done;
    logic [DNUM_W-1:0] div_num, div_quot;
    logic [DDEN_W-1:0] div_den;
    logic             take;
    logic [ERR_W-1:0] cand_err;
    logic [MPW-1:0]   cand_den;

    pll_req_clamp #(.FW(FW)) u_clamp (
        .req_i     (req_khz),
        .vco_min_i (vco_min_khz),
        .max_out_i (max_out_khz),
        .req_o     (req_eff)
    );

    pll_div_restoring #(.NUM_W(DNUM_W), .DEN_W(DDEN_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .done_o  (div_done),
        .quot_o  (div_quot)
    );

    pll_cand_eval #(.FW(FW), .QW(DNUM_W), .ERR_W(ERR_W), .DEN_W(MPW)) u_eval (
        .req_i      (req_r),
        .ref_i      (ref_r),
        .m_i        (m_q),
        .pe_i       (pe_q),
        .n_i        (n_q),
        .found_i    (found_q),
        .best_err_i (best_err_q),
        .best_den_i (best_den_q),
        .take_o     (take),
        .err_o      (cand_err),
        .den_o      (cand_den)
    );

    // scan position bookkeeping
    always_comb begin
        fvco     = VW'(req_r) << pe_q;
        vco_bad  = (fvco < VW'(vmin_r)) || (fvco > VW'(vmax_r));
        win_pass = win_ok(32'(ref_r), 32'(m_q), WIN_LO_KHZ, WIN_HI_KHZ);
        adv_p    = vco_bad || (m_q == M_W'(M_LAST));
        scan_end = adv_p && (pe_q == PE_W'(P_STEPS - 1));
    end

    // divider operand selection
    always_comb begin
        div_start = 1'b0;
        div_num   = '0;
        div_den   = '0;
        if (state_q == ST_SCAN && !vco_bad && win_pass) begin
            div_start = 1'b1;
            div_num   = ((DNUM_W'(fvco) * DNUM_W'(m_q)) << 1) + DNUM_W'(ref_r);
            div_den   = DDEN_W'(ref_r) << 1;
        end else if (state_q == ST_FIN && found_q) begin
            div_start = 1'b1;
            div_num   = DNUM_W'(ref_r) * DNUM_W'(best_q.n);
            div_den   = DDEN_W'(MPW'(best_q.m) << best_q.pe);
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign m_sel    = sel_q.m;
    assign n_sel    = sel_q.n;
    assign p_code   = sel_q.pe;
    assign pll_byte = pack_byte(sel_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            req_r        <= '0;
            ref_r        <= '0;
            vmin_r       <= '0;
            vmax_r       <= '0;
            maxo_r       <= '0;
            pe_q         <= '0;
            m_q          <= '0;
            n_q          <= '0;
            found_q      <= 1'b0;
            best_q       <= '0;
            best_err_q   <= '0;
            best_den_q   <= '0;
            sel_q        <= '0;
            achieved_khz <= '0;
            done         <= 1'b0;
            invalid      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        req_r      <= req_eff;
                        ref_r      <= ref_khz;
                        vmin_r     <= vco_min_khz;
                        vmax_r     <= vco_max_khz;
                        maxo_r     <= max_out_khz;
                        pe_q       <= '0;
                        m_q        <= M_W'(M_FIRST);
                        found_q    <= 1'b0;
                        best_q     <= '0;
                        best_err_q <= '0;
                        best_den_q <= '0;
                        done       <= 1'b0;
                        invalid    <= 1'b0;
                        state_q    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (div_start) begin
                        state_q <= ST_DIVN;
                    end else if (scan_end) begin
                        state_q <= ST_FIN;
                    end else if (adv_p) begin
                        pe_q <= pe_q + 1'b1;
                        m_q  <= M_W'(M_FIRST);
                    end else begin
                        m_q <= m_q + 1'b1;
                    end
                end
                ST_DIVN: begin
                    if (div_done) begin
                        n_q     <= div_quot;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (take) begin
                        best_q     <= '{pe: pe_q, m: m_q, n: n_q[N_W-1:0]};
                        best_err_q <= cand_err;
                        best_den_q <= cand_den;
                        found_q    <= 1'b1;
                    end
                    if (scan_end) begin
                        state_q <= ST_FIN;
                    end else begin
                        state_q <= ST_SCAN;
                        if (adv_p) begin
                            pe_q <= pe_q + 1'b1;
                            m_q  <= M_W'(M_FIRST);
                        end else begin
                            m_q <= m_q + 1'b1;
                        end
                    end
                end
                ST_FIN: begin
                    if (found_q) begin
                        state_q <= ST_DIVF;
                    end else begin
                        sel_q        <= '0;
                        achieved_khz <= '0;
                        invalid      <= 1'b1;
                        done         <= 1'b1;
                        state_q      <= ST_IDLE;
                    end
                end
                ST_DIVF: begin
                    if (div_done) begin
                        sel_q        <= best_q;
                        achieved_khz <= (|div_quot[DNUM_W-1:FW]) ? '1 : div_quot[FW-1:0];
                        done         <= 1'b1;
                        state_q      <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: the latched request never exceeds the output ceiling
    a_r1_clamp_ceiling: assert property (@(posedge clk) disable iff (rst)
        busy |-> (req_r <= maxo_r));

    // R2: a multiplier division only runs for a VCO frequency inside the range
    a_r2_vco_in_range: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIVN) |-> ((fvco >= VW'(vmin_r)) && (fvco <= VW'(vmax_r))));

    // R3: a scored reference divider sits inside the phase-detector window
    a_r3_window_kept: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIVN) |->
            ((32'(ref_r) >= 32'(WIN_LO_KHZ) * 32'(m_q)) &&
             (32'(ref_r) <= 32'(WIN_HI_KHZ) * 32'(m_q)) && (m_q != '0)));

    // R7: a valid result carries an N and M inside their ranges
    a_r7_valid_fields: assert property (@(posedge clk) disable iff (rst)
        (done && !invalid) |-> ((n_sel != '0) && (m_sel != '0)));

    // R9: an empty search reports all-zero settings
    a_r9_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        invalid |-> ((m_sel == '0) && (n_sel == '0) && (p_code == '0) &&
                     (pll_byte == '0) && (achieved_khz == '0)));

    // R10: busy and done are mutually exclusive, and a start clears done
    a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    a_r10_start_clears_done: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !done));
endmodule

// File: tb/pll_divider_search_bench.sv
`timescale 1ns/1ps
module pll_divider_search_bench;
    localparam int FW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [FW-1:0] req_khz = '0, ref_khz = '0, vco_min_khz = '0, vco_max_khz = '0, max_out_khz = '0;
    logic          busy, done, invalid;
    logic [5:0]    m_sel;
    logic [6:0]    n_sel;
    logic [1:0]    p_code;
    logic [7:0]    pll_byte;
    logic [FW-1:0] achieved_khz;

    pll_divider_search u_pll_divider_search (
        .clk, .rst, .start, .req_khz, .ref_khz, .vco_min_khz, .vco_max_khz, .max_out_khz,
        .busy, .done, .invalid, .m_sel, .n_sel, .p_code, .pll_byte, .achieved_khz
    );

    always #10 clk = ~clk;   // 50 MHz

    int     n_cmp = 0;
    int     n_bad = 0;
    bit     exp_on = 1'b0;
    bit     finished = 1'b0;
    longint e_m, e_n, e_p, e_inv, e_ach;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model straight from the requirements
    task automatic model(input longint rq, input longint rf, input longint vn,
                         input longint vx, input longint mx);
        longint rc, bm, bn, bpe, be, bd;
        bit     found;
        rc = rq;
        if (rc < vn / 8) rc = vn / 8;           // R1
        if (rc > mx) rc = mx;
        found = 0; bm = 0; bn = 0; bpe = 0; be = 0; bd = 1;
        for (int pe = 0; pe < 4; pe++) begin    // R2
            longint p, fv;
            p  = longint'(1) << pe;
            fv = rc * p;
            if (fv < vn || fv > vx) continue;
            for (int m = 1; m <= 63; m++) begin  // R3
                longint n, e, d;
                if (rf < 2000 * m || rf > 3600 * m) continue;
                n = (2 * fv * m + rf) / (2 * rf);   // R4
                if (n < 1 || n > 127) continue;
                e = rc * m * p - rf * n;
                if (e < 0) e = -e;
                d = m * p;
                if (!found || e * bd < be * d) begin  // R5
                    found = 1; bm = m; bn = n; bpe = pe; be = e; bd = d;
                end
            end
        end
        if (found) begin
            e_m = bm; e_n = bn; e_p = bpe; e_inv = 0;
            e_ach = (rf * bn) / (bm << bpe);
            if (e_ach > (longint'(1) << FW) - 1) e_ach = (longint'(1) << FW) - 1;
        end else begin
            e_m = 0; e_n = 0; e_p = 0; e_inv = 1; e_ach = 0;
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R10 busy and done together", longint'(busy && done), 0);
            if (done && exp_on) begin
                chk("R3 R5 m_sel",        m_sel, e_m);
                chk("R4 R5 n_sel",        n_sel, e_n);
                chk("R2 R6 p_code",       p_code, e_p);
                chk("R7 pll_byte",        pll_byte, (e_p << 6) | e_m);
                chk("R1 R8 achieved_khz", achieved_khz, e_ach);
                chk("R9 invalid",         invalid, e_inv);
            end
        end
    end

    task automatic run_job(input longint rq, input longint rf, input longint vn,
                           input longint vx, input longint mx, input bit poke);
        int guard;
        @(posedge clk); #1;
        req_khz = FW'(rq); ref_khz = FW'(rf); vco_min_khz = FW'(vn);
        vco_max_khz = FW'(vx); max_out_khz = FW'(mx);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        model(rq, rf, vn, vx, mx);
        exp_on = 1'b1;
        @(negedge clk);
        chk("R10 busy after start", busy, 1);
        chk("R10 done cleared by start", done, 0);
        if (poke) begin
            // R10: start during a search must be ignored
            repeat (4) @(posedge clk);
            #1;
            req_khz = FW'(rq / 2 + 777); ref_khz = FW'(27000); start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 8000) begin
            @(posedge clk);
            guard++;
        end
        if (!done) chk("R10 done within bound", 0, 1);
        // R10: results hold while inputs change without a start
        #1;
        req_khz = FW'(12345); ref_khz = FW'(9999); max_out_khz = FW'(1);
        repeat (6) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 invalid", invalid, 0);
        chk("R11 pll_byte", pll_byte, 0);
        chk("R11 n_sel", n_sel, 0);
        chk("R11 achieved_khz", achieved_khz, 0);

        run_job(25175, 14318, 300000, 600000, 200000, 0);   // R2 P=8 region
        run_job(65000, 14318, 300000, 600000, 200000, 0);
        run_job(108000, 14318, 300000, 600000, 200000, 1);  // R10 ignored start
        run_job(10000, 14318, 300000, 600000, 200000, 0);   // R1 raised to floor
        run_job(300000, 14318, 300000, 600000, 200000, 0);  // R1 lowered to ceiling
        run_job(50000, 1000, 300000, 600000, 200000, 0);    // R9 window empty
        run_job(100000, 14318, 500000, 510000, 200000, 0);  // R2 R9 no VCO fit
        run_job(135000, 27000, 300000, 600000, 200000, 0);
        run_job(200000, 7200, 300000, 600000, 200000, 0);   // R4 large N rejected
        run_job(40000, 3600, 300000, 600000, 200000, 0);    // R3 upper window edge
        run_job(40000, 2000, 300000, 600000, 200000, 0);    // R3 lower edge, R4 N>127
        run_job(74250, 14318, 300000, 600000, 200000, 0);   // R9 cleared again

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule